// File: doc/BRIEF.md
# Master-Clock Ratio Detector and Sample-Tick Resynchronizer

This block runs on the master system clock of an audio converter and watches the sample-rate word clock, which arrives from outside and is first passed through a two-flop synchronizer. It counts master clocks between successive rising word-clock edges. It decides whether the master clock runs at 256 or 384 times the sample rate, and it declares lock once two periods in a row agree.

While locked, it produces a one-cycle sample tick once per sample period, on a schedule that it keeps itself. At every word-clock edge it measures how far the edge sits from the tick it expected. Small offsets are ignored. When the offset goes beyond a slip threshold, the schedule is realigned to the edge. At the same time the downstream sample path is told to repeat the previous sample (edge arrived late) or to drop the next one (edge arrived early), which keeps the audible click small.

Top module: `clk_ratio_resync`

## Requirements
- R1: The word clock is sampled through two flops and then compared with a third flop to find a rising edge. All reactions to a word-clock edge appear at the outputs on the third master-clock edge after the input rises.
- R2: A period count (master clocks between two observed rising edges) in 248..264 is class 256, and a count in 376..392 is class 384. The first edge after reset is not measured. Two consecutive measurements of the same class set `locked`. Any measurement in neither class clears `locked` at once.
- R3: `ratio_384` is 0 for 256 and 1 for 384. It changes only when two consecutive measurements agree on the new class. A single measurement of the other class leaves both `ratio_384` and `locked` unchanged.
- R4: `sample_tick` is never high while `locked` is low. While locked with no slip, it pulses for one cycle every 256 or 384 cycles, as `ratio_384` selects. The edge that declares lock aligns the schedule so that a tick coincides with each later aligned edge.
- R5: While locked, an edge whose offset from the expected tick is at most 16 master clocks produces no command and does not move the schedule. Offsets accumulate across periods.
- R6: While locked, an edge that arrives more than 16 clocks after the expected tick (offset up to half a period) gives a one-cycle `repeat_cmd` and realigns the schedule to that edge.
- R7: While locked, an edge that arrives more than 16 clocks before the expected tick gives a one-cycle `drop_cmd` and realigns the schedule. `repeat_cmd` and `drop_cmd` are never high together, and neither is high unless the block was locked in the cycle before.
- R8: After synchronous reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wclk_in | input | 1 | Sample-rate word clock, asynchronous at the pin |
| ratio_384 | output | 1 | Detected ratio: 0 = 256, 1 = 384 |
| locked | output | 1 | Ratio detected and stable |
| sample_tick | output | 1 | One-cycle pulse per sample period while locked |
| repeat_cmd | output | 1 | One-cycle request to repeat the previous sample |
| drop_cmd | output | 1 | One-cycle request to drop the next sample |

## Verification
The hardest state to reach is a severe slip while lock is still held. A single period long or short enough to exceed the slip threshold also falls outside the classification window, so it unlocks the block. The stimulus therefore drifts the word clock slowly: several periods of 263 or 249 clocks each stay inside the class. Their offsets of 7 clocks add up until the third edge crosses 16, which gives a repeat or a drop while `locked` stays high. A behavioural model in the bench predicts every output on every clock, and directed counts confirm the single commands and the tick rate.

// File: rtl/clk_ratio_pkg.sv
// Shared parameters and types for the clock-ratio detector.
// Assumes the two supported ratios differ by much more than twice the tolerance.
package clk_ratio_pkg;

    // Classification result of one measured word-clock period.
    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_LO   = 2'd1,
        CLS_HI   = 2'd2
    } ratio_cls_t;

    // Default ratio, window and slip values.
    localparam int DEF_RATIO_LO = 256;
    localparam int DEF_RATIO_HI = 384;
    localparam int DEF_TOL      = 8;
    localparam int DEF_SLIP     = 16;

endpackage

// File: rtl/wclk_edge_sync.sv
// Brings the asynchronous word clock into the master domain through two flops.
// A third flop delays the synchronized copy, and a rising edge shows as a one-cycle
// pulse. Assumes the word clock stays high and low for at least two master clocks each.
module wclk_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic wclk_in,
    output logic wclk_rise
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-stage synchronizer followed by the edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= wclk_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Rising edge of the synchronized word clock.
    assign wclk_rise = sync_q & ~prev_q;

endmodule

// File: rtl/period_classifier.sv
// Counts master clocks between rising word-clock edges and classifies each period.
// A count within TOL of RATIO_LO or RATIO_HI is classed as that ratio; any other
// count is CLS_NONE. The first edge after reset starts the counter but is not reported.
module period_classifier
    import clk_ratio_pkg::*;
#(
    parameter int RATIO_LO = DEF_RATIO_LO,
    parameter int RATIO_HI = DEF_RATIO_HI,
    parameter int TOL      = DEF_TOL
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wclk_rise,
    output logic       meas_valid,
    output ratio_cls_t meas_cls
);

    localparam int CW = $clog2(RATIO_HI + TOL + 1) + 1;

    logic [CW-1:0] per_cnt;
    logic          seen_q;
    int            cnt_val;

    // Period counter: restarts at one on each edge and saturates at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_cnt <= '0;
        end else if (wclk_rise) begin
            per_cnt <= CW'(1);
        end else if (per_cnt != '1) begin
            per_cnt <= per_cnt + CW'(1);
        end
    end

    // Remembers that one edge has been seen, so later counts are full periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (wclk_rise) begin
            seen_q <= 1'b1;
        end
    end

    // Window comparison of the finished count against both ratios.
    always_comb begin
        cnt_val = int'(per_cnt);
        if (cnt_val >= RATIO_LO - TOL && cnt_val <= RATIO_LO + TOL) begin
            meas_cls = CLS_LO;
        end else if (cnt_val >= RATIO_HI - TOL && cnt_val <= RATIO_HI + TOL) begin
            meas_cls = CLS_HI;
        end else begin
            meas_cls = CLS_NONE;
        end
    end

    assign meas_valid = wclk_rise & seen_q;

endmodule

// File: rtl/lock_tracker.sv
// Turns per-period classifications into a lock flag and a detected ratio.
// Lock is declared, or the ratio changed, only after two matching classifications
// in a row. An unclassifiable period drops lock at once.
module lock_tracker
    import clk_ratio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       meas_valid,
    input  ratio_cls_t meas_cls,
    output logic       locked,
    output logic       ratio_hi
);

    ratio_cls_t cand_q;

    // Candidate class, lock flag and ratio, updated once per measured period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q   <= CLS_NONE;
            locked   <= 1'b0;
            ratio_hi <= 1'b0;
        end else if (meas_valid) begin
            if (meas_cls == CLS_NONE) begin
                cand_q <= CLS_NONE;
                locked <= 1'b0;
            end else if (meas_cls == cand_q) begin
                locked   <= 1'b1;
                ratio_hi <= (meas_cls == CLS_HI);
            end else begin
                cand_q <= meas_cls;
            end
        end
    end

endmodule

// File: rtl/tick_scheduler.sv
// Keeps the sample-tick phase counter and checks it against each word-clock edge.
// The phase and ratio it uses are those held before the edge. Unlocked edges always
// realign without a command. Locked edges realign only when the offset exceeds SLIP,
// and then raise repeat (late edge) or drop (early edge) for one cycle.
module tick_scheduler
    import clk_ratio_pkg::*;
#(
    parameter int RATIO_LO = DEF_RATIO_LO,
    parameter int RATIO_HI = DEF_RATIO_HI,
    parameter int SLIP     = DEF_SLIP
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wclk_rise,
    input  logic locked,
    input  logic ratio_hi,
    output logic sample_tick,
    output logic repeat_cmd,
    output logic drop_cmd
);

    localparam int PW = $clog2(RATIO_HI);

    logic [PW-1:0] phase_q;
    logic [PW-1:0] phase_nxt;
    logic [PW-1:0] phase_last;
    int            per_len;
    int            ph;
    logic          late_sev;
    logic          early_sev;

    // Period length and last phase value for the ratio in force.
    always_comb begin
        per_len    = ratio_hi ? RATIO_HI : RATIO_LO;
        phase_last = ratio_hi ? PW'(RATIO_HI - 1) : PW'(RATIO_LO - 1);
        ph         = int'(phase_q);
    end

    // Severity of the offset between the edge and the expected tick.
    always_comb begin
        late_sev  = (ph <= per_len / 2) && (ph > SLIP);
        early_sev = (ph > per_len / 2) && ((per_len - ph) > SLIP);
    end

    // Next phase: free-running wrap, or realignment to the edge.
    always_comb begin
        phase_nxt = (phase_q >= phase_last) ? '0 : phase_q + PW'(1);
        if (wclk_rise && (!locked || late_sev || early_sev)) begin
            phase_nxt = PW'(1);
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_nxt;
        end
    end

    // One-cycle slip commands, issued only while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            repeat_cmd <= 1'b0;
            drop_cmd   <= 1'b0;
        end else begin
            repeat_cmd <= wclk_rise & locked & late_sev;
            drop_cmd   <= wclk_rise & locked & early_sev;
        end
    end

    assign sample_tick = locked && (phase_q == '0);

endmodule

// File: rtl/clk_ratio_resync.sv
// Top of the ratio detector and resynchronizer. It chains the word-clock
// synchronizer, the period classifier, the lock tracker and the tick scheduler.
// Assumes the master clock is free running and that reset is synchronous to it.
module clk_ratio_resync
    import clk_ratio_pkg::*;
#(
    parameter int RATIO_LO = DEF_RATIO_LO,
    parameter int RATIO_HI = DEF_RATIO_HI,
    parameter int TOL      = DEF_TOL,
    parameter int SLIP     = DEF_SLIP
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wclk_in,
    output logic ratio_384,
    output logic locked,
    output logic sample_tick,
    output logic repeat_cmd,
    output logic drop_cmd
);

    logic       wclk_rise;
    logic       meas_valid;
    ratio_cls_t meas_cls;

    wclk_edge_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .wclk_in   (wclk_in),
        .wclk_rise (wclk_rise)
    );

    period_classifier #(
        .RATIO_LO (RATIO_LO),
        .RATIO_HI (RATIO_HI),
        .TOL      (TOL)
    ) u_class (
        .clk        (clk),
        .rst_n      (rst_n),
        .wclk_rise  (wclk_rise),
        .meas_valid (meas_valid),
        .meas_cls   (meas_cls)
    );

    lock_tracker u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_valid (meas_valid),
        .meas_cls   (meas_cls),
        .locked     (locked),
        .ratio_hi   (ratio_384)
    );

    tick_scheduler #(
        .RATIO_LO (RATIO_LO),
        .RATIO_HI (RATIO_HI),
        .SLIP     (SLIP)
    ) u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .wclk_rise   (wclk_rise),
        .locked      (locked),
        .ratio_hi    (ratio_384),
        .sample_tick (sample_tick),
        .repeat_cmd  (repeat_cmd),
        .drop_cmd    (drop_cmd)
    );

endmodule

// File: rtl/clk_ratio_resync_checker.sv
// Port-level properties of the ratio detector, bound to every instance of the top.
module clk_ratio_resync_checker (
    input logic clk,
    input logic rst_n,
    input logic ratio_384,
    input logic locked,
    input logic sample_tick,
    input logic repeat_cmd,
    input logic drop_cmd
);

    assert_tick_only_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |-> locked);

    assert_tick_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |=> !sample_tick);

    assert_ratio_moves_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio_384) |-> locked);

    assert_repeat_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_cmd |=> !repeat_cmd);

    assert_cmd_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(repeat_cmd && drop_cmd));

    assert_cmd_needs_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (repeat_cmd || drop_cmd) |-> $past(locked));

endmodule

bind clk_ratio_resync clk_ratio_resync_checker i_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .ratio_384   (ratio_384),
    .locked      (locked),
    .sample_tick (sample_tick),
    .repeat_cmd  (repeat_cmd),
    .drop_cmd    (drop_cmd)
);

// File: tb/test_clk_ratio_resync.sv
// Self-checking bench: a behavioural model predicts all outputs every clock.
module test_clk_ratio_resync;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wclk_in = 1'b0;
    logic ratio_384, locked, sample_tick, repeat_cmd, drop_cmd;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    clk_ratio_resync i_clk_ratio_resync (
        .clk         (clk),
        .rst_n       (rst_n),
        .wclk_in     (wclk_in),
        .ratio_384   (ratio_384),
        .locked      (locked),
        .sample_tick (sample_tick),
        .repeat_cmd  (repeat_cmd),
        .drop_cmd    (drop_cmd)
    );

    // ---------------- reference model ----------------
    bit m_s1, m_s2, m_s3, m_seen, m_lk, m_hi, m_rep, m_drp, m_rise;
    int m_cnt, m_pos, m_cand, m_len, m_next, m_cls;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_seen = 0; m_lk = 0; m_hi = 0;
            m_rep = 0; m_drp = 0; m_cnt = 0; m_pos = 0; m_cand = 0;
        end else begin
            m_rise = m_s2 && !m_s3;
            m_len  = m_hi ? 384 : 256;
            m_rep  = 0;
            m_drp  = 0;
            m_next = (m_pos >= m_len - 1) ? 0 : m_pos + 1;
            if (m_rise) begin
                if (!m_lk) m_next = 1;
                else if (m_pos <= m_len / 2) begin
                    if (m_pos > 16) begin m_rep = 1; m_next = 1; end
                end else if (m_len - m_pos > 16) begin
                    m_drp = 1; m_next = 1;
                end
            end
            if (m_rise && m_seen) begin
                if (m_cnt >= 248 && m_cnt <= 264) m_cls = 1;
                else if (m_cnt >= 376 && m_cnt <= 392) m_cls = 2;
                else m_cls = 0;
                if (m_cls == 0) begin m_lk = 0; m_cand = 0; end
                else if (m_cls == m_cand) begin m_lk = 1; m_hi = (m_cls == 2); end
                else m_cand = m_cls;
            end
            m_cnt  = m_rise ? 1 : m_cnt + 1;
            if (m_rise) m_seen = 1;
            m_pos  = m_next;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = wclk_in;
        end
    end

    // ---------------- per-clock comparison ----------------
    int n_rep = 0, n_drp = 0, n_tick = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (locked !== m_lk) begin
                errors++; $display("FAIL R2 locked act=%b exp=%b t=%0t", locked, m_lk, $time);
            end
            if (ratio_384 !== m_hi) begin
                errors++; $display("FAIL R3 ratio_384 act=%b exp=%b t=%0t", ratio_384, m_hi, $time);
            end
            if (sample_tick !== (m_lk && m_pos == 0)) begin
                errors++; $display("FAIL R4 R1 sample_tick act=%b exp=%b t=%0t",
                                   sample_tick, (m_lk && m_pos == 0), $time);
            end
            if (repeat_cmd !== m_rep) begin
                errors++; $display("FAIL R6 repeat_cmd act=%b exp=%b t=%0t", repeat_cmd, m_rep, $time);
            end
            if (drop_cmd !== m_drp) begin
                errors++; $display("FAIL R7 drop_cmd act=%b exp=%b t=%0t", drop_cmd, m_drp, $time);
            end
            if (repeat_cmd === 1'b1) n_rep++;
            if (drop_cmd === 1'b1) n_drp++;
            if (sample_tick === 1'b1) n_tick++;
        end
    end

    // ---------------- helpers ----------------
    task automatic wperiod(input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            wclk_in = (i < len / 2);
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    int rep0, drp0, tick0;

    initial begin
        repeat (5) @(negedge clk);
        // R8: reset state
        check("R8 outputs in reset", {ratio_384, locked, sample_tick, repeat_cmd, drop_cmd}, 0);
        rst_n = 1;
        @(negedge clk);
        check("R8 outputs after reset", {ratio_384, locked, sample_tick, repeat_cmd, drop_cmd}, 0);

        // R1: reaction latency; first measured edge pair cannot lock yet
        wperiod(256); wperiod(256);
        check("R2 no lock after one measurement", locked, 0);
        wperiod(256); wperiod(256);
        check("R2 lock at 256", locked, 1);
        check("R3 ratio is 256", ratio_384, 0);

        // R4: one tick per period while aligned
        tick0 = n_tick;
        for (int k = 0; k < 4; k++) wperiod(256);
        check("R4 ticks over four periods", n_tick - tick0, 4);

        // R5: jitter within slip threshold
        rep0 = n_rep; drp0 = n_drp;
        wperiod(261); wperiod(251); wperiod(256);
        check("R5 no repeat on small offset", n_rep - rep0, 0);
        check("R5 no drop on small offset", n_drp - drp0, 0);
        check("R5 lock kept", locked, 1);

        // R6: late drift accumulates into one repeat
        rep0 = n_rep;
        wperiod(263); wperiod(263); wperiod(263); wperiod(256);
        check("R6 one repeat after late drift", n_rep - rep0, 1);
        check("R6 lock kept", locked, 1);

        // R7: early drift accumulates into one drop
        drp0 = n_drp; rep0 = n_rep;
        wperiod(249); wperiod(249); wperiod(249); wperiod(256);
        check("R7 one drop after early drift", n_drp - drp0, 1);
        check("R7 no repeat on early drift", n_rep - rep0, 0);

        // R3: one period of the other class changes nothing
        wperiod(384); wperiod(256);
        check("R3 ratio kept after single 384", ratio_384, 0);
        check("R3 lock kept after single 384", locked, 1);

        // R3: two consecutive 384 periods switch ratio
        wperiod(384); wperiod(384); wperiod(384);
        check("R3 ratio switched to 384", ratio_384, 1);
        tick0 = n_tick;
        wperiod(384); wperiod(384);
        check("R4 ticks at 384 ratio", n_tick - tick0, 2);

        // R2: unclassifiable period drops lock
        wperiod(320); wperiod(384);
        check("R2 unlock on 320 period", locked, 0);
        tick0 = n_tick;
        wperiod(100);
        check("R4 no ticks while unlocked", n_tick - tick0, 0);
        wperiod(384); wperiod(384); wperiod(384);
        check("R2 relock at 384", locked, 1);
        check("R3 ratio 384 after relock", ratio_384, 1);

        repeat (10) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule